// File: doc/BRIEF.md
# TDC FIFO Readout Controller

This block sits in the FPGA next to an external time-to-digital converter that keeps its measurement results in two on-chip FIFOs, each with an active-high empty flag. The controller watches both flags. When a FIFO holds a result, it places that FIFO's address on a 4-bit address bus and pulls an active-low read strobe. It then samples the 28-bit word that the converter drives onto a shared tristate bus. The word is split into a channel number, an 8-bit start count and a 17-bit fine time in 81 ps steps.

The converter raises an interrupt flag that follows the top bit of its start counter. Each falling edge of that flag means the start counter has rolled over. The controller counts these edges, so every timestamp it emits carries an extended coarse count of `{wrap count, start count, fine time}`. Results leave the block as a valid/ready stream. A word whose marker bit is clear is dropped and reported with a one-cycle error pulse.

Top module: `tdc_fifo_reader`

## Requirements
- R1: While reset is held, busRdN is 1, tsValid is 0, protoErr is 0 and busAddr is 8. The wrap count restarts at 0.
- R2: A read is launched only from idle, on a FIFO whose empty flag was low in the deciding cycle. FIFO A (channels 0 to 3) uses address 8 and FIFO B (channels 4 to 7) uses address 9. While both flags are high, no read is made.
- R3: busRdN stays low for exactly RD_LOW cycles (default 2). The bus is sampled on the last low cycle only, so a value present only in the first low cycle has no effect.
- R4: After each read, busRdN stays high for at least GAP_CYC cycles (default 1) before the next fall.
- R5: When both FIFOs are non-empty, reads alternate between them, starting with FIFO A after reset.
- R6: From the word read, tsChannel = {fifo index (A=0, B=1), word[27:26]}, the start field of tsStamp = word[25:18] and the fine field of tsStamp = word[16:0].
- R7: A word with bit 17 equal to 0 produces no output. protoErr pulses high for exactly one cycle instead.
- R8: The wrap count in tsStamp[WRAP_W+24:25] goes up by one on each falling edge of intFlag, sampled on clk.
- R9: If the word's start bit 7 (word[25]) is 1 while the last sampled intFlag is 0, the word belongs to the previous epoch, and the emitted wrap count is the current count minus 1.
- R10: While tsValid is 1 and tsReady is 0, tsValid, tsChannel and tsStamp stay unchanged, and no new read starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoEmptyA | input | 1 | High while the converter's first FIFO is empty |
| fifoEmptyB | input | 1 | High while the converter's second FIFO is empty |
| intFlag | input | 1 | Converter flag following start counter bit 7 |
| busAddr | output | 4 | Converter register address |
| busRdN | output | 1 | Active-low read strobe |
| busData | inout | 28 | Shared tristate data bus, driven by the converter during reads |
| tsValid | output | 1 | Timestamp available |
| tsReady | input | 1 | Consumer accepts the timestamp |
| tsChannel | output | 3 | Full channel number 0..7 |
| tsStamp | output | WRAP_W+25 | {wrap count, start count, fine time} |
| protoErr | output | 1 | One-cycle pulse for a discarded word |

## Verification
The strobe falls on the edge after the idle cycle that sees a low empty flag. It rises RD_LOW edges later. The result (tsValid or protoErr) appears on that same rising edge, so it can be seen from the following falling clock edge. The bench samples every output at falling edges and waits a bounded number of cycles for each result. It measures the strobe's low and high runs cycle by cycle, which checks the strobe width separately from the data. The converter model drives a word with bit 17 clear during the first low cycle, so sampling too early shows up as a spurious error. Wrap-count cases change intFlag several cycles away from any capture, so the expected count is unambiguous.

// File: rtl/tdc_rd_pkg.sv
package tdc_rd_pkg;
  localparam int WORD_W  = 28;
  localparam int FINE_W  = 17;
  localparam int START_W = 8;
  localparam logic [3:0] ADDR_FIFO_A = 4'd8;
  localparam logic [3:0] ADDR_FIFO_B = 4'd9;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_GAP} rdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic launch;   // a read starts this edge
    logic pickB;    // which FIFO the starting read targets
    logic capture;  // last low strobe cycle: sample the bus
  } rdCtrl_t;
endpackage

// File: rtl/tdc_rd_ctrl.sv
module tdc_rd_ctrl
  import tdc_rd_pkg::*;
#(
  parameter int RD_LOW  = 2,
  parameter int GAP_CYC = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    fifoEmptyA,
  input  logic    fifoEmptyB,
  input  logic    outBusy,
  output rdCtrl_t ctrl,
  output logic    rdActive
);
  localparam int CNT_MAX = (RD_LOW > GAP_CYC) ? RD_LOW : GAP_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  rdState_t   state;
  logic [CNT_W-1:0] cnt;
  logic       lastB;
  logic       wantA, wantB, goRead, pickB;

  assign wantA  = !fifoEmptyA;
  assign wantB  = !fifoEmptyB;
  assign pickB  = wantB && (!wantA || !lastB);
  assign goRead = (state == ST_IDLE) && !outBusy && (wantA || wantB);

  assign ctrl.launch  = goRead;
  assign ctrl.pickB   = pickB;
  assign ctrl.capture = (state == ST_READ) && (cnt == CNT_W'(RD_LOW - 1));
  assign rdActive     = (state == ST_READ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      lastB <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: if (goRead) begin
          state <= ST_READ;
          cnt   <= '0;
          lastB <= pickB;
        end
        ST_READ: if (cnt == CNT_W'(RD_LOW - 1)) begin
          state <= ST_GAP;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        ST_GAP: if (cnt == CNT_W'(GAP_CYC - 1)) begin
          state <= ST_IDLE;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tdc_rd_datapath.sv
module tdc_rd_datapath
  import tdc_rd_pkg::*;
#(
  parameter int WRAP_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  rdCtrl_t             ctrl,
  input  logic [WORD_W-1:0]   busWord,
  input  logic                intFlag,
  input  logic                tsReady,
  output logic [3:0]          busAddr,
  output logic                tsValid,
  output logic [2:0]          tsChannel,
  output logic [WRAP_W+START_W+FINE_W-1:0] tsStamp,
  output logic                protoErr
);
  logic              selB;
  logic              intSeen;
  logic [WRAP_W-1:0] wrapCnt;
  logic [WRAP_W-1:0] wrapForWord;
  logic              oldEpoch;

  assign busAddr     = selB ? ADDR_FIFO_B : ADDR_FIFO_A;
  // upper-half start value seen after the flag already fell: prior epoch
  assign oldEpoch    = busWord[25] && !intSeen;
  assign wrapForWord = wrapCnt - WRAP_W'(oldEpoch);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selB    <= 1'b0;
      intSeen <= 1'b0;
      wrapCnt <= '0;
    end else begin
      intSeen <= intFlag;
      if (intSeen && !intFlag) wrapCnt <= wrapCnt + 1'b1;
      if (ctrl.launch) selB <= ctrl.pickB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tsValid   <= 1'b0;
      tsChannel <= '0;
      tsStamp   <= '0;
      protoErr  <= 1'b0;
    end else begin
      protoErr <= ctrl.capture && !busWord[17];
      if (ctrl.capture && busWord[17]) begin
        tsValid   <= 1'b1;
        tsChannel <= {selB, busWord[27:26]};
        tsStamp   <= {wrapForWord, busWord[25:18], busWord[16:0]};
      end else if (tsValid && tsReady) begin
        tsValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tdc_fifo_reader.sv
module tdc_fifo_reader
  import tdc_rd_pkg::*;
#(
  parameter int RD_LOW  = 2,
  parameter int GAP_CYC = 1,
  parameter int WRAP_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoEmptyA,
  input  logic              fifoEmptyB,
  input  logic              intFlag,
  output logic [3:0]        busAddr,
  output logic              busRdN,
  inout  wire  [27:0]       busData,
  output logic              tsValid,
  input  logic              tsReady,
  output logic [2:0]        tsChannel,
  output logic [WRAP_W+24:0] tsStamp,
  output logic              protoErr
);
  rdCtrl_t ctrl;
  logic    rdActive;

  assign busRdN = !rdActive;

  tdc_rd_ctrl #(.RD_LOW(RD_LOW), .GAP_CYC(GAP_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoEmptyA(fifoEmptyA), .fifoEmptyB(fifoEmptyB),
    .outBusy(tsValid), .ctrl(ctrl), .rdActive(rdActive)
  );

  tdc_rd_datapath #(.WRAP_W(WRAP_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .busWord(busData), .intFlag(intFlag),
    .tsReady(tsReady), .busAddr(busAddr), .tsValid(tsValid),
    .tsChannel(tsChannel), .tsStamp(tsStamp), .protoErr(protoErr)
  );
endmodule

// File: rtl/tdc_fifo_reader_chk.sv
module tdc_fifo_reader_chk #(
  parameter int RD_LOW  = 2,
  parameter int GAP_CYC = 1,
  parameter int WRAP_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              fifoEmptyA,
  input logic              fifoEmptyB,
  input logic [3:0]        busAddr,
  input logic              busRdN,
  input logic              tsValid,
  input logic              tsReady,
  input logic [2:0]        tsChannel,
  input logic [WRAP_W+24:0] tsStamp,
  input logic              protoErr
);
  logic [7:0] lowRun, highRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun  <= '0;
      highRun <= 8'hFF;
    end else if (busRdN) begin
      lowRun <= '0;
      if (highRun != 8'hFF) highRun <= highRun + 1'b1;
    end else begin
      highRun <= '0;
      if (lowRun != 8'hFF) lowRun <= lowRun + 1'b1;
    end
  end

  // R2: a read only targets a FIFO that was non-empty, at address 8 or 9
  a_r2_nonempty_target: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busRdN) |-> ((busAddr == 4'd8) ? !$past(fifoEmptyA)
                      : ((busAddr == 4'd9) && !$past(fifoEmptyB))));

  // R2: address held for the whole strobe
  a_r2_addr_steady: assert property (@(posedge clk) disable iff (!rstN)
    (!busRdN && $past(!busRdN)) |-> $stable(busAddr));

  // R3: strobe width
  a_r3_strobe_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busRdN) |-> (lowRun == 8'(RD_LOW)));

  // R4: idle time between reads
  a_r4_gap_kept: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busRdN) |-> (highRun >= 8'(GAP_CYC)));

  // R7: discarded word gives a single pulse and no output
  a_r7_err_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> !tsValid);
  a_r7_err_single: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> !protoErr);

  // R10: output held under backpressure, no read meanwhile
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (tsValid && !tsReady) |=> (tsValid && $stable(tsStamp) && $stable(tsChannel)));
  a_r10_no_read: assert property (@(posedge clk) disable iff (!rstN)
    tsValid |-> busRdN);
endmodule

bind tdc_fifo_reader tdc_fifo_reader_chk #(
  .RD_LOW(RD_LOW), .GAP_CYC(GAP_CYC), .WRAP_W(WRAP_W)
) u_chk (
  .clk(clk), .rstN(rstN), .fifoEmptyA(fifoEmptyA), .fifoEmptyB(fifoEmptyB),
  .busAddr(busAddr), .busRdN(busRdN), .tsValid(tsValid), .tsReady(tsReady),
  .tsChannel(tsChannel), .tsStamp(tsStamp), .protoErr(protoErr)
);

// File: tb/test_tdc_fifo_reader.sv
module test_tdc_fifo_reader;
  localparam int WRAP_W = 16;
  localparam int SW = WRAP_W + 25;

  typedef struct packed {
    logic        sel;
    logic [1:0]  ch;
    logic [7:0]  start;
    logic        mark;
    logic [16:0] fine;
    logic        expErr;
    logic [2:0]  expChan;
  } vec_t;

  localparam vec_t VECS[8] = '{
    '{1'b0, 2'd0, 8'h00, 1'b1, 17'h00000, 1'b0, 3'd0},
    '{1'b0, 2'd3, 8'h7F, 1'b1, 17'h1FFFF, 1'b0, 3'd3},
    '{1'b1, 2'd0, 8'h12, 1'b1, 17'h00001, 1'b0, 3'd4},
    '{1'b1, 2'd3, 8'h55, 1'b1, 17'h0ABCD, 1'b0, 3'd7},
    '{1'b0, 2'd2, 8'h33, 1'b0, 17'h01234, 1'b1, 3'd0},
    '{1'b1, 2'd1, 8'h40, 1'b1, 17'h10000, 1'b0, 3'd5},
    '{1'b1, 2'd2, 8'h01, 1'b0, 17'h00000, 1'b1, 3'd0},
    '{1'b0, 2'd1, 8'h7E, 1'b1, 17'h15555, 1'b0, 3'd1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic intFlag = 1'b0;
  logic tsReady = 1'b1;
  logic [3:0] busAddr;
  logic busRdN, tsValid, protoErr;
  logic [2:0] tsChannel;
  logic [SW-1:0] tsStamp;
  wire  [27:0] busData;
  logic fifoEmptyA, fifoEmptyB;

  int total = 0;
  int bad = 0;
  int pops = 0;

  always #5ns clk = ~clk;

  // converter model
  logic [27:0] qA[8];
  logic [27:0] qB[8];
  logic [2:0] hA = 0, tA = 0, hB = 0, tB = 0;
  int nA = 0, nB = 0;
  int lowCycles = 0;
  logic [27:0] drive;

  assign fifoEmptyA = (nA == 0);
  assign fifoEmptyB = (nB == 0);
  assign drive = (lowCycles == 0) ? 28'h0 : ((busAddr == 4'd9) ? qB[hB] : qA[hA]);
  assign busData = busRdN ? 28'bz : drive;

  always @(posedge clk) lowCycles <= busRdN ? 0 : lowCycles + 1;

  always @(posedge busRdN) begin
    if (rstN) begin
      pops++;
      if (busAddr == 4'd8 && nA > 0) begin hA = hA + 1; nA--; end
      else if (busAddr == 4'd9 && nB > 0) begin hB = hB + 1; nB--; end
      else begin
        total++; bad++;
        $display("FAIL R2 read of empty or unknown FIFO: actual addr=%0d expected a non-empty FIFO", busAddr);
      end
    end
  end

  // strobe run monitor
  int curLow = 0, lastLow = 0, curHigh = 0, minGap = 1000;
  always @(negedge clk) begin
    if (!rstN) begin curLow = 0; curHigh = 0; end
    else if (!busRdN) begin
      if (curLow == 0 && curHigh < minGap && pops > 0) minGap = curHigh;
      curLow++; curHigh = 0;
    end else begin
      if (curLow != 0) lastLow = curLow;
      curLow = 0; curHigh++;
    end
  end

  tdc_fifo_reader #(.RD_LOW(2), .GAP_CYC(1), .WRAP_W(WRAP_W)) i_tdc_fifo_reader (
    .clk(clk), .rstN(rstN), .fifoEmptyA(fifoEmptyA), .fifoEmptyB(fifoEmptyB),
    .intFlag(intFlag), .busAddr(busAddr), .busRdN(busRdN), .busData(busData),
    .tsValid(tsValid), .tsReady(tsReady), .tsChannel(tsChannel),
    .tsStamp(tsStamp), .protoErr(protoErr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic sel, input logic [1:0] ch, input logic [7:0] st,
                      input logic mark, input logic [16:0] fine);
    if (!sel) begin qA[tA] = {ch, st, mark, fine}; tA = tA + 1; nA++; end
    else      begin qB[tB] = {ch, st, mark, fine}; tB = tB + 1; nB++; end
  endtask

  task automatic doReset();
    rstN = 1'b0; tsReady = 1'b1; intFlag = 1'b0;
    hA = 0; tA = 0; hB = 0; tB = 0; nA = 0; nB = 0; pops = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // kind: 0 none, 1 timestamp, 2 error
  task automatic waitResult(output int kind, output logic [2:0] ch, output logic [SW-1:0] st);
    kind = 0; ch = '0; st = '0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (protoErr) begin kind = 2; return; end
      if (tsValid) begin kind = 1; ch = tsChannel; st = tsStamp; return; end
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1ms;
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finishRun();
  end

  initial begin
    int kind;
    logic [2:0] ch;
    logic [SW-1:0] st;
    logic [SW-1:0] held;

    // R1 reset state
    repeat (2) @(negedge clk);
    check("R1 busRdN in reset", busRdN, 1);
    check("R1 tsValid in reset", tsValid, 0);
    check("R1 protoErr in reset", protoErr, 0);
    check("R1 busAddr in reset", busAddr, 8);
    rstN = 1'b1;

    // R2: both empty, nothing read
    repeat (12) @(negedge clk);
    check("R2 no read while empty", pops, 0);
    check("R2 strobe idle while empty", busRdN, 1);

    // table walk: R6, R7, R3 (first-cycle junk would give spurious errors)
    for (int i = 0; i < 8; i++) begin
      push(VECS[i].sel, VECS[i].ch, VECS[i].start, VECS[i].mark, VECS[i].fine);
      waitResult(kind, ch, st);
      if (VECS[i].expErr) begin
        check("R7 marker clear gives error", kind, 2);
        check("R7 no output with error", tsValid, 0);
      end else begin
        check("R6 result kind", kind, 1);
        check("R6 channel", ch, VECS[i].expChan);
        check("R6 stamp", st, {16'h0, VECS[i].start, VECS[i].fine});
      end
      repeat (3) @(negedge clk);
    end
    check("R7 error pulse gone", protoErr, 0);
    check("R3 strobe low length", lastLow, 2);
    check("R4 idle gap at least one", (minGap >= 1), 1);

    // R5 round robin right after reset
    doReset();
    @(negedge clk);
    push(0, 2'd0, 8'h01, 1, 17'h11);
    push(0, 2'd2, 8'h02, 1, 17'h22);
    push(1, 2'd1, 8'h03, 1, 17'h33);
    push(1, 2'd3, 8'h04, 1, 17'h44);
    waitResult(kind, ch, st); check("R5 first pick FIFO A", ch, 0);
    waitResult(kind, ch, st); check("R5 then FIFO B", ch, 5);
    waitResult(kind, ch, st); check("R5 back to A", ch, 2);
    waitResult(kind, ch, st); check("R5 then B again", ch, 7);
    check("R5 fine of last", st[16:0], 17'h44);

    // R10 backpressure
    doReset();
    tsReady = 1'b0;
    push(0, 2'd1, 8'h21, 1, 17'h0BEEF);
    push(0, 2'd2, 8'h22, 1, 17'h0CAFE);
    waitResult(kind, ch, st);
    held = st;
    repeat (6) @(negedge clk);
    check("R10 valid held", tsValid, 1);
    check("R10 stamp held", tsStamp, held);
    check("R10 channel held", tsChannel, 1);
    check("R10 no second read", pops, 1);
    tsReady = 1'b1;
    @(negedge clk);
    check("R10 accepted", tsValid, 0);
    waitResult(kind, ch, st);
    check("R10 second word after release", st[16:0], 17'h0CAFE);

    // R8 / R9 wrap extension
    doReset();
    for (int k = 0; k < 3; k++) begin
      intFlag = 1'b1; repeat (3) @(negedge clk);
      intFlag = 1'b0; repeat (3) @(negedge clk);
    end
    push(0, 2'd0, 8'h05, 1, 17'h7);
    waitResult(kind, ch, st);
    check("R8 three wraps", st[SW-1:25], 3);
    intFlag = 1'b1; repeat (4) @(negedge clk);
    push(0, 2'd0, 8'h90, 1, 17'h8);
    waitResult(kind, ch, st);
    check("R9 upper half with flag high", st[SW-1:25], 3);
    intFlag = 1'b0; repeat (4) @(negedge clk);
    push(0, 2'd0, 8'hF0, 1, 17'h9);
    waitResult(kind, ch, st);
    check("R9 prior-epoch word", st[SW-1:25], 3);
    check("R9 start kept", st[24:17], 8'hF0);
    repeat (3) @(negedge clk);
    push(1, 2'd0, 8'h02, 1, 17'hA);
    waitResult(kind, ch, st);
    check("R8 four wraps", st[SW-1:25], 4);

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule